// File: doc/BRIEF.md
# Serial Converter Read-Out Sequencer

This block models the digital side of a 12-bit sampling converter that a host reads over an SPI-style, read-only link. The host pulls chip select low and toggles the serial clock. The block answers on its data pin. It first sends one low null bit. It then sends the captured result with the most significant bit first, and then the same result again with the least significant bit first, without sending bit 0 a second time. After that it sends zeros for as long as clocks keep arriving. The analog front end is not modelled. A parallel sample word from a stand-in converter is latched at the moment the sample window closes.

Chip select and the serial clock are asynchronous to the block clock. Both pass through synchronizers, and all edge detection happens in the block clock domain, so each serial-clock edge takes effect a few block-clock cycles after it occurs. The block also drives two observation signals. One is a level that marks the sample window. The other is a one-cycle strobe that marks the capture of the sample word.

The core drives the data bit together with a separate output enable. Only the top level combines the two into a real three-state pin.

Top module: `sat_adc_out`

## Requirements
- R1: A frame starts only when chip select falls from high to low. Between that fall and the second falling serial-clock edge, `dout_en` stays 0.
- R2: If chip select is low when reset is released, the block ignores all clocks: `dout_en`, `sample_win` and `conv_capture` stay 0 until chip select has gone high and then low again.
- R3: `sample_win` rises after the first rising serial-clock edge of a frame. It falls at the second falling edge. At that same edge, `conv_capture` pulses for one clock and the pin is enabled, driving the null bit 0.
- R4: The data bit changes only as a result of a falling serial-clock edge. It is updated within 4 block clocks of that edge and holds through the following high phase.
- R5: Falling edges 3 to 14 of a frame drive the captured word from bit 11 down to bit 0.
- R6: Falling edges 15 to 25 drive bits 1 up to 11 in ascending order. Bit 0 is not repeated.
- R7: Falling edge 26 and every later falling edge, while chip select stays low, drive 0.
- R8: While chip select is high, `dout_en` is 0, and `dout` is high impedance.
- R9: The sample word is latched once per frame, at the capture strobe. Changes to `sample_word` after that have no effect on the bits sent.
- R10: Raising chip select at any point ends the frame. The next chip-select fall starts a clean frame that begins with the null bit on its second falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sample_word | input | RES | Parallel result from the stand-in converter |
| dout | output | 1 | Three-state serial data pin |
| dout_en | output | 1 | High while the data pin is driven |
| sample_win | output | 1 | High during the sample window |
| conv_capture | output | 1 | One-cycle strobe when the sample word is latched |

## Verification
Three things happen on the second falling edge of a frame: the sample window closes, the word is captured, and the null bit is driven. A wrong ordering among them would show up as a stale word or a late enable. After that edge, the bench checks in the same low phase that the window is low, that the capture count rose by exactly one, and that the pin is enabled and driving 0. A second test changes the parallel word two edges after the capture. It then checks that every later data bit still matches the word that was present at the capture edge.

// File: rtl/sat_adc_pkg.sv
package sat_adc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT_RISE,
    SEQ_SAMPLE,
    SEQ_XFER
  } seq_state_e;

  // width of the falling-edge index, which saturates at 2*res+2
  function automatic int idx_width(input int res);
    return $clog2(2 * res + 3);
  endfunction

endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    if (STAGES > 1) begin : g_deep
      always_comb pipe_d = {pipe_q[STAGES-2:0], async_in[g]};
    end else begin : g_single
      always_comb pipe_d = async_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end

    assign level[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/sat_frame_seq.sv
module sat_frame_seq
  import sat_adc_pkg::*;
#(
  parameter int RES = 12,
  parameter int CW  = idx_width(RES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_lvl,
  input  logic          sclk_lvl,
  output logic [CW-1:0] idx,
  output logic          step,
  output logic          capture,
  output logic          sample_win,
  output logic          armed
);

  localparam logic [CW-1:0] IDX_NULL = CW'(2);
  localparam logic [CW-1:0] IDX_ZERO = CW'(2 * RES + 2);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          step_q, step_d;
  logic          cap_q, cap_d;
  logic          armed_q, armed_d;
  logic          cs_prev_q, sclk_prev_q;
  logic          cs_fall, sclk_rise, sclk_fall;

  // edges of the synchronized levels
  always_comb begin
    cs_fall   = cs_prev_q & ~cs_lvl;
    sclk_rise = ~sclk_prev_q & sclk_lvl;
    sclk_fall = sclk_prev_q & ~sclk_lvl;
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    step_d  = 1'b0;
    cap_d   = 1'b0;
    armed_d = armed_q | cs_lvl;
    if (cs_lvl) begin
      st_d  = SEQ_IDLE;
      idx_d = '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (cs_fall && armed_q) begin
            st_d  = SEQ_WAIT_RISE;
            idx_d = '0;
          end
        end
        SEQ_WAIT_RISE: begin
          if (sclk_rise) st_d = SEQ_SAMPLE;
        end
        SEQ_SAMPLE: begin
          if (sclk_fall) begin
            if (idx_q == IDX_NULL - CW'(1)) begin
              st_d   = SEQ_XFER;
              cap_d  = 1'b1;
              step_d = 1'b1;
              idx_d  = IDX_NULL;
            end else begin
              idx_d = idx_q + CW'(1);
            end
          end
        end
        SEQ_XFER: begin
          if (sclk_fall) begin
            step_d = 1'b1;
            if (idx_q != IDX_ZERO) idx_d = idx_q + CW'(1);
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_IDLE;
      idx_q       <= '0;
      step_q      <= 1'b0;
      cap_q       <= 1'b0;
      armed_q     <= 1'b0;
      cs_prev_q   <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      idx_q       <= idx_d;
      step_q      <= step_d;
      cap_q       <= cap_d;
      armed_q     <= armed_d;
      cs_prev_q   <= cs_lvl;
      sclk_prev_q <= sclk_lvl;
    end
  end

  assign idx        = idx_q;
  assign step       = step_q;
  assign capture    = cap_q;
  assign sample_win = (st_q == SEQ_SAMPLE);
  assign armed      = armed_q;

endmodule

// File: rtl/sat_bit_path.sv
module sat_bit_path
  import sat_adc_pkg::*;
#(
  parameter int RES = 12,
  parameter int CW  = idx_width(RES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_lvl,
  input  logic           step,
  input  logic           capture,
  input  logic [CW-1:0]  idx,
  input  logic [RES-1:0] word_in,
  output logic           dout_bit,
  output logic           dout_en
);

  localparam logic [CW-1:0] IDX_FIRST = CW'(3);
  localparam logic [CW-1:0] IDX_HI    = CW'(RES + 2);
  localparam logic [CW-1:0] IDX_ZERO  = CW'(2 * RES + 2);

  logic [RES-1:0] word_q, word_d;
  logic           bit_q, bit_d;
  logic           oe_q, oe_d;
  logic [CW-1:0]  sel;
  logic           take;
  logic           pick;

  // map the falling-edge index to a bit of the held word
  always_comb begin
    sel  = '0;
    take = 1'b0;
    if (idx >= IDX_FIRST && idx <= IDX_HI) begin
      sel  = IDX_HI - idx;
      take = 1'b1;
    end else if (idx > IDX_HI && idx < IDX_ZERO) begin
      sel  = idx - IDX_HI;
      take = 1'b1;
    end
  end

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < RES; i++) begin
      if (take && sel == CW'(i)) pick = word_q[i];
    end
  end

  always_comb begin
    word_d = capture ? word_in : word_q;
    bit_d  = step ? pick : bit_q;
    if (cs_lvl)    oe_d = 1'b0;
    else if (step) oe_d = 1'b1;
    else           oe_d = oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      bit_q  <= bit_d;
      oe_q   <= oe_d;
    end
  end

  assign dout_bit = bit_q;
  assign dout_en  = oe_q;

endmodule

// File: rtl/sat_adc_out.sv
module sat_adc_out
  import sat_adc_pkg::*;
#(
  parameter int RES         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic [RES-1:0] sample_word,
  output wire            dout,
  output logic           dout_en,
  output logic           sample_win,
  output logic           conv_capture
);

  localparam int CW = idx_width(RES);

  logic [1:0]    rst_pipe_q;
  logic          rst_core_n;
  logic [1:0]    sync_lvl;
  logic          cs_lvl;
  logic          sclk_lvl;
  logic [CW-1:0] idx;
  logic          step;
  logic          armed;
  logic          dout_bit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  sat_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in ({sclk, cs_n}),
    .level    (sync_lvl)
  );
  assign cs_lvl   = sync_lvl[0];
  assign sclk_lvl = sync_lvl[1];

  sat_frame_seq #(.RES(RES), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cs_lvl     (cs_lvl),
    .sclk_lvl   (sclk_lvl),
    .idx        (idx),
    .step       (step),
    .capture    (conv_capture),
    .sample_win (sample_win),
    .armed      (armed)
  );

  sat_bit_path #(.RES(RES), .CW(CW)) u_bits (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cs_lvl   (cs_lvl),
    .step     (step),
    .capture  (conv_capture),
    .idx      (idx),
    .word_in  (sample_word),
    .dout_bit (dout_bit),
    .dout_en  (dout_en)
  );

  assign dout = dout_en ? dout_bit : 1'bz;

endmodule

// File: rtl/sat_adc_out_chk.sv
module sat_adc_out_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic dout_en,
  input logic dout_bit,
  input logic sample_win,
  input logic conv_capture,
  input logic step,
  input logic armed
);

  AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !dout_en); // R8

  AST_BIT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en && $past(dout_en) && !$past(step) |-> $stable(dout_bit)); // R4

  AST_NULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> !dout_bit); // R3

  AST_CAPTURE_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    conv_capture |-> $past(sample_win) && !sample_win); // R3

  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !dout_en && !sample_win && !conv_capture); // R2

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_capture |=> !conv_capture); // R9

endmodule

bind sat_adc_out sat_adc_out_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .dout_en      (dout_en),
  .dout_bit     (dout_bit),
  .sample_win   (sample_win),
  .conv_capture (conv_capture),
  .step         (step),
  .armed        (armed)
);

// File: tb/sim_sat_adc_out.sv
module sim_sat_adc_out;

  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int RES   = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cs_n;
  logic           sclk;
  logic [RES-1:0] sample_word;
  wire            dout;
  logic           dout_en;
  logic           sample_win;
  logic           conv_capture;

  int checks = 0;
  int errors = 0;
  int cap_cnt = 0;
  bit done = 1'b0;

  sat_adc_out #(.RES(RES)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .sample_word  (sample_word),
    .dout         (dout),
    .dout_en      (dout_en),
    .sample_win   (sample_win),
    .conv_capture (conv_capture)
  );

  always #(CLK_P / 2) clk = ~clk;

  always @(posedge clk) if (conv_capture) cap_cnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [RES-1:0] w, input int k);
    if (k >= 3 && k <= 14)  return w[14 - k];
    if (k >= 15 && k <= 25) return w[k - 14];
    return 1'b0;
  endfunction

  function automatic string tag_of(input int k);
    if (k < 2)   return "R1";
    if (k == 2)  return "R3";
    if (k <= 14) return "R5";
    if (k <= 25) return "R6";
    return "R7";
  endfunction

  // one frame of nclk serial clocks; chg alters the parallel word after capture
  task automatic run_frame(input logic [RES-1:0] w, input int nclk,
                           input bit chg, input string tag);
    int cap0;
    logic prev_bit;
    string t;
    sample_word = w;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(dout_en == 1'b0 && sample_win == 1'b0, "R1", "idle after cs fall",
        {dout_en, sample_win}, 0);
    cap0 = cap_cnt;
    prev_bit = 1'b0;
    for (int k = 1; k <= nclk; k++) begin
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (k == 1) chk(sample_win == 1'b1, "R3", "window open", sample_win, 1);
      if (k >= 3) chk(dout === prev_bit, "R4", "hold in high phase", dout, prev_bit);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      t = (tag != "") ? tag : tag_of(k);
      if (k < 2) begin
        chk(dout_en == 1'b0, t, "no drive before null", dout_en, 0);
      end else begin
        chk(dout_en == 1'b1 && dout === exp_bit(w, k), t, $sformatf("edge %0d", k),
            {dout_en, dout}, {1'b1, exp_bit(w, k)});
        prev_bit = dout;
      end
      if (k == 2) begin
        chk(sample_win == 1'b0, "R3", "window closed", sample_win, 0);
        chk(cap_cnt == cap0 + 1, "R3", "one capture strobe", cap_cnt - cap0, 1);
      end
      if (chg && k == 4) sample_word = ~w;
    end
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk(dout_en == 1'b0, "R8", "released after cs high", dout_en, 0);
    if (nclk >= 2) chk(cap_cnt == cap0 + 1, "R9", "single capture per frame", cap_cnt - cap0, 1);
  endtask

  task automatic t_powerup_low();
    for (int k = 0; k < 15; k++) begin
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      chk(dout_en == 1'b0 && sample_win == 1'b0, "R2", "unarmed edge",
          {dout_en, sample_win}, 0);
    end
    chk(cap_cnt == 0, "R2", "no capture while unarmed", cap_cnt, 0);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    run_frame(12'hA5C, 15, 1'b0, "");
  endtask

  task automatic t_frame15();  run_frame(12'h3C7, 15, 1'b0, ""); endtask
  task automatic t_frame26();  run_frame(12'h9B1, 26, 1'b0, ""); endtask
  task automatic t_zeros();    run_frame(12'hFFF, 32, 1'b0, ""); endtask
  task automatic t_word_hold(); run_frame(12'h5A3, 26, 1'b1, "R9"); endtask

  task automatic t_abort();
    run_frame(12'hFFF, 7, 1'b0, "");
    run_frame(12'h001, 16, 1'b0, "R10");
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b0;
    sclk = 1'b0;
    sample_word = '0;
    repeat (4) @(negedge clk);
    chk(dout_en == 1'b0 && sample_win == 1'b0 && conv_capture == 1'b0, "R8",
        "reset state", {dout_en, sample_win, conv_capture}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_powerup_low();
    t_frame15();
    t_frame26();
    t_zeros();
    t_abort();
    t_word_hold();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule